// File: doc/BRIEF.md
# Product-Term Cluster Steering Allocator

This block sits between the product-term array of one logic block and its sixteen macrocells. Each macrocell slot owns one cluster sum. A cluster can stay with its own macrocell, or it can be pushed forward along a fixed expansion chain. Sixteen macrocells form four chains. Each chain links every fourth macrocell and wraps from its last member back to its first. Forwarding is transitive: a cluster that enters a member which also forwards travels on. It stops at the first member that keeps its slot, and there it is OR-combined with that member's own cluster. Every member that forwards presents logic 0 at its own output.

The routing from cluster inputs to macrocell sums is purely combinational. Only the steering configuration is stored, one 2-bit code per macrocell. Software loads it one entry per cycle through a plain write port, and reset clears it to all-local. Two static flags report configurations that cannot be built. The first marks a chain whose four members all forward, which forms a ring. The second marks a destination that would gather more product terms than its chain allows. Every cluster carries `PT_PER_CLUSTER` product terms, and the chain limits are 75, 80, 75 and 70.

Top module: `pterm_steer_alloc`

## Requirements
- R1: After reset every steering code is local (00), so `mc_sum` equals `cluster_sum`, and both `loop_error` and `limit_error` are 0.
- R2: When `cfg_we` is high at a rising clock edge, the code on `cfg_code` is stored for macrocell `cfg_idx`. The routing changes from that edge on, and not before it.
- R3: Code 00 keeps a macrocell's cluster in its own slot.
- R4: Code 01 forwards everything a macrocell holds (its own cluster plus anything forwarded into it) to the next member of its chain, which is index+4 modulo 16. That macrocell's own `mc_sum` bit is then 0.
- R5: Codes 10 and 11 are reserved and behave exactly like 00.
- R6: A non-forwarding macrocell outputs the OR of its own cluster and the clusters of the unbroken run of forwarding members that lead into it along its chain. A `cluster_sum` of all zeros gives an `mc_sum` of all zeros.
- R7: Chains wrap around: macrocells 12 to 15 forward into macrocells 0 to 3.
- R8: When all four members of any chain forward, `loop_error` is 1 and all four outputs of that chain are 0. Otherwise `loop_error` is 0.
- R9: A non-forwarding macrocell gathers `PT_PER_CLUSTER` × (1 + length of its incoming run) product terms. `limit_error` is 1 when any such count exceeds the limit of its chain. The chain is the index modulo 4, and the limits for chains 0 to 3 are 75, 80, 75 and 70. With the default of 20 terms per cluster, a run of three flags chains 0, 2 and 3 but not chain 1.
- R10: Chains are independent: no cluster ever reaches a macrocell of another chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst_n | input | 1 | Active-low reset, clears every code to local |
| cfg_we | input | 1 | Write enable for one steering code |
| cfg_idx | input | 4 | Macrocell whose code is written |
| cfg_code | input | 2 | Steering code: 00 local, 01 forward, 10/11 reserved (local) |
| cluster_sum | input | 16 | Cluster sum of each macrocell slot |
| mc_sum | output | 16 | Allocated sum delivered to each macrocell |
| loop_error | output | 1 | Some chain forwards around a full ring |
| limit_error | output | 1 | Some destination exceeds its chain's product-term limit |

## Verification
A wrong stored code has no internal place to hide. It shows at the ports in the very next cycle, as a cluster that is missing or duplicated in `mc_sum`, or as a wrong flag. This holds only if the bench drives a `cluster_sum` pattern that lights that chain. For this reason every configuration is read back under several input patterns, including single walking bits and all-ones. The bench sweeps all sixteen forward patterns of each chain, and the non-forwarding slots of each sweep rotate through codes 00, 10 and 11. The other chains carry different patterns during the sweep, so a cross-chain leak appears as an extra bit in the wrong macrocell.

// File: rtl/pta_pkg.sv
package pta_pkg;
  typedef enum logic [1:0] {
    STEER_LOCAL = 2'b00,
    STEER_NEXT  = 2'b01,
    STEER_RSV2  = 2'b10,
    STEER_RSV3  = 2'b11
  } steer_code_e;

  // Only the forward code moves a cluster; reserved codes act as local.
  function automatic logic is_forward(input logic [1:0] code);
    return code == STEER_NEXT;
  endfunction
endpackage

// File: rtl/pta_cfg_store.sv
module pta_cfg_store #(
  parameter int NUM_MC = 16,
  localparam int IDX_W = $clog2(NUM_MC)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [1:0]            wr_code,
  output logic [2*NUM_MC-1:0]   code_flat,
  output logic [NUM_MC-1:0]     fwd
);
  import pta_pkg::*;

  steer_code_e code_q [NUM_MC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_MC; i++) code_q[i] <= STEER_LOCAL;
    end else if (wr_en) begin
      code_q[wr_idx] <= steer_code_e'(wr_code);
    end
  end

  for (genvar g = 0; g < NUM_MC; g++) begin : g_out
    assign code_flat[2*g +: 2] = code_q[g];
    assign fwd[g]              = is_forward(code_q[g]);
  end
endmodule

// File: rtl/pta_chain_route.sv
module pta_chain_route #(
  parameter int LEN            = 4,
  parameter int PT_PER_CLUSTER = 20,
  parameter int LIM_W          = 8
) (
  input  logic [LEN-1:0]       cl,
  input  logic [LEN-1:0]       fwd,
  output logic [LEN-1:0]       sum,
  output logic [LEN*LIM_W-1:0] pt_cnt
);
  always_comb begin
    sum    = '0;
    pt_cnt = '0;
    for (int k = 0; k < LEN; k++) begin
      logic alive;
      logic acc;
      int   run;
      alive = 1'b1;
      acc   = cl[k];
      run   = 0;
      // walk backwards over the run of forwarding predecessors
      for (int s = 1; s < LEN; s++) begin
        int p;
        p = (k - s + LEN) % LEN;
        if (alive && fwd[p]) begin
          acc = acc | cl[p];
          run = run + 1;
        end else begin
          alive = 1'b0;
        end
      end
      if (!fwd[k]) begin
        sum[k]                 = acc;
        pt_cnt[k*LIM_W +: LIM_W] = LIM_W'((run + 1) * PT_PER_CLUSTER);
      end
    end
  end
endmodule

// File: rtl/pta_chain_check.sv
module pta_chain_check #(
  parameter int              LEN   = 4,
  parameter int              LIM_W = 8,
  parameter logic [LIM_W-1:0] LIMIT = 8'd75
) (
  input  logic [LEN-1:0]       fwd,
  input  logic [LEN*LIM_W-1:0] pt_cnt,
  output logic                 loop_o,
  output logic                 over_o
);
  assign loop_o = &fwd;

  always_comb begin
    over_o = 1'b0;
    for (int k = 0; k < LEN; k++) begin
      if (pt_cnt[k*LIM_W +: LIM_W] > LIMIT) over_o = 1'b1;
    end
  end
endmodule

// File: rtl/pterm_steer_alloc.sv
module pterm_steer_alloc #(
  parameter int NUM_MC         = 16,
  parameter int NUM_CHAINS     = 4,
  parameter int PT_PER_CLUSTER = 20,
  parameter int LIM_W          = 8,
  parameter logic [NUM_CHAINS*LIM_W-1:0] CHAIN_PT_LIMIT = {8'd70, 8'd75, 8'd80, 8'd75},
  localparam int IDX_W     = $clog2(NUM_MC),
  localparam int CHAIN_LEN = NUM_MC / NUM_CHAINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [1:0]        cfg_code,
  input  logic [NUM_MC-1:0] cluster_sum,
  output logic [NUM_MC-1:0] mc_sum,
  output logic              loop_error,
  output logic              limit_error
);
  logic [2*NUM_MC-1:0]  code_q;
  logic [NUM_MC-1:0]    fwd;
  logic [NUM_CHAINS-1:0] ch_loop;
  logic [NUM_CHAINS-1:0] ch_over;

  pta_cfg_store #(.NUM_MC(NUM_MC)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_idx),
    .wr_code(cfg_code), .code_flat(code_q), .fwd(fwd)
  );

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    logic [CHAIN_LEN-1:0]       cl;
    logic [CHAIN_LEN-1:0]       fw;
    logic [CHAIN_LEN-1:0]       sm;
    logic [CHAIN_LEN*LIM_W-1:0] cnt;

    for (genvar k = 0; k < CHAIN_LEN; k++) begin : g_member
      assign cl[k]                      = cluster_sum[k*NUM_CHAINS + c];
      assign fw[k]                      = fwd[k*NUM_CHAINS + c];
      assign mc_sum[k*NUM_CHAINS + c]   = sm[k];
    end

    pta_chain_route #(
      .LEN(CHAIN_LEN), .PT_PER_CLUSTER(PT_PER_CLUSTER), .LIM_W(LIM_W)
    ) u_route (.cl(cl), .fwd(fw), .sum(sm), .pt_cnt(cnt));

    pta_chain_check #(
      .LEN(CHAIN_LEN), .LIM_W(LIM_W), .LIMIT(CHAIN_PT_LIMIT[c*LIM_W +: LIM_W])
    ) u_check (.fwd(fw), .pt_cnt(cnt), .loop_o(ch_loop[c]), .over_o(ch_over[c]));
  end

  assign loop_error  = |ch_loop;
  assign limit_error = |ch_over;
endmodule

// File: rtl/pterm_steer_alloc_chk.sv
module pterm_steer_alloc_chk #(
  parameter int NUM_MC     = 16,
  parameter int NUM_CHAINS = 4,
  localparam int IDX_W     = $clog2(NUM_MC),
  localparam int CHAIN_LEN = NUM_MC / NUM_CHAINS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [IDX_W-1:0]  cfg_idx,
  input logic [1:0]        cfg_code,
  input logic [NUM_MC-1:0] cluster_sum,
  input logic [NUM_MC-1:0] mc_sum,
  input logic              loop_error,
  input logic [2*NUM_MC-1:0] code_q
);
  for (genvar i = 0; i < NUM_MC; i++) begin : g_mc
    AST_FWD_SLOT_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      (code_q[2*i +: 2] == 2'b01) |-> !mc_sum[i]); // R4
    AST_KEEP_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
      (code_q[2*i +: 2] != 2'b01 && cluster_sum[i]) |-> mc_sum[i]); // R3 R5
    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_idx == IDX_W'(i)) |=> code_q[2*i +: 2] == $past(cfg_code)); // R2
  end

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_ring
    logic ring;
    always_comb begin
      ring = 1'b1;
      for (int k = 0; k < CHAIN_LEN; k++)
        if (code_q[2*(k*NUM_CHAINS + c) +: 2] != 2'b01) ring = 1'b0;
    end
    AST_RING_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      ring |-> loop_error); // R8
  end

  AST_QUIET_IN_QUIET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (cluster_sum == '0) |-> (mc_sum == '0)); // R6
endmodule

bind pterm_steer_alloc pterm_steer_alloc_chk #(.NUM_MC(NUM_MC), .NUM_CHAINS(NUM_CHAINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_code(cfg_code),
  .cluster_sum(cluster_sum), .mc_sum(mc_sum), .loop_error(loop_error), .code_q(code_q)
);

// File: tb/pterm_steer_alloc_bench.sv
module pterm_steer_alloc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [1:0]  cfg_code = '0;
  logic [15:0] cluster_sum = '0;
  logic [15:0] mc_sum;
  logic        loop_error, limit_error;

  int total = 0;
  int bad = 0;
  logic [1:0] bcode [16];
  int lim [4] = '{75, 80, 75, 70};

  always #5 clk = ~clk;

  pterm_steer_alloc u_pterm_steer_alloc (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_code(cfg_code),
    .cluster_sum(cluster_sum), .mc_sum(mc_sum), .loop_error(loop_error), .limit_error(limit_error)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_code(input int idx, input logic [1:0] code);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_code = code;
    bcode[idx] = code;
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  // forward-walk model: follow each source until it lands or loops
  task automatic model(input logic [15:0] cl, output logic [15:0] sums,
                       output logic loop_e, output logic lim_e);
    int hits [16];
    sums = '0; loop_e = 1'b0; lim_e = 1'b0;
    for (int j = 0; j < 16; j++) hits[j] = 0;
    for (int i = 0; i < 16; i++) begin
      int j; int steps;
      j = i; steps = 0;
      while (bcode[j] == 2'b01 && steps < 4) begin
        j = (j + 4) % 16; steps++;
      end
      if (steps < 4) begin
        hits[j]++;
        if (cl[i]) sums[j] = 1'b1;
      end else loop_e = 1'b1;
    end
    for (int j = 0; j < 16; j++)
      if (hits[j] * 20 > lim[j % 4]) lim_e = 1'b1;
  endtask

  task automatic probe(input logic [15:0] cl, input string tag);
    logic [15:0] es; logic el; logic ex;
    @(negedge clk);
    cluster_sum = cl;
    #1;
    model(cl, es, el, ex);
    check(tag, mc_sum, es);
    check("R8 loop_error", {15'b0, loop_error}, {15'b0, el});
    check("R9 limit_error", {15'b0, limit_error}, {15'b0, ex});
  endtask

  initial begin
    for (int i = 0; i < 16; i++) bcode[i] = 2'b00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state is all-local
    probe(16'h0000, "R1 reset");
    probe(16'hFFFF, "R1 reset");
    probe(16'hA5C3, "R1 reset");

    // R2: write becomes visible only after the capturing edge
    @(negedge clk);
    cluster_sum = 16'h0020;
    cfg_we = 1'b1; cfg_idx = 4'd5; cfg_code = 2'b01;
    #1 check("R2 before edge", mc_sum, 16'h0020);
    @(posedge clk);
    #1 cfg_we = 1'b0;
    bcode[5] = 2'b01;
    check("R2 after edge R4", mc_sum, 16'h0200);
    write_code(5, 2'b00);

    // R7: wrap from macrocell 13 into macrocell 1
    write_code(13, 2'b01);
    probe(16'h2000, "R7 wrap");
    write_code(13, 2'b00);

    // sweep every forward pattern of every chain, rotating local codes
    for (int c = 0; c < 4; c++) begin
      for (int pat = 0; pat < 16; pat++) begin
        for (int m = 0; m < 16; m++) begin
          int ch; int mem; int q; logic [1:0] lc;
          ch = m % 4; mem = m / 4;
          q = (ch == c) ? pat : ((pat * 3 + ch) & 15);
          case ((m + pat) % 3)
            0: lc = 2'b00;
            1: lc = 2'b10;
            default: lc = 2'b11;
          endcase
          write_code(m, q[mem] ? 2'b01 : lc);
        end
        probe(16'h0000, "R6 quiet");
        probe(16'hFFFF, "R3 R4 R5 R6 all-ones");
        probe(16'h1 << pat, "R4 R6 R7 R10 walk");
        probe(16'h1 << (pat + c) % 16, "R4 R6 R7 R10 walk");
        probe(16'h1111 << c, "R6 R10 chain");
        probe(~(16'h1111 << c), "R10 other chains");
        probe(16'hA5C3 ^ 16'(pat * 16'h0913), "R3 R5 R6 mixed");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule